// File: doc/BRIEF.md
# Adjustable Synchronization Timer

This peripheral keeps two independent 32-bit time bases behind a small word-addressed register port with single-cycle writes and combinational reads. The first is a periodic counter. It counts up to a programmable limit, wraps to zero, and drives a set of compare channels. Each channel emits a one-clock pulse when the count arrives at that channel's value.

The second is a synchronization timer that free-runs when enabled. Software corrects it with self-clearing command bits in the control word. One command clears it, one loads an adjustment value, one adds that value, and one subtracts it. A rising edge on an external trigger input copies the timer's value into a capture register. Each time base can be set to freeze while a debug-halt input is high.

Top module: `sync_timer_unit`

## Requirements
- R1: While reset is held low, every readable register reads zero and no compare output is high.
- R2: With control bit 0 set, the periodic counter (byte address 0x0C) rises by one on each clock. In the clock after it equals the limit register (0x04), it becomes zero. While control bit 1 is set, the counter is forced to zero instead.
- R3: When control bit 2 is set, a high debug-halt input holds the periodic counter at its value.
- R4: Compare channel k (byte address 0x20 + 4k) raises bit k of `cmp_hit` for exactly one clock, in the cycle in which a counting step has just changed the counter to that channel's value. A forced clear does not raise it.
- R5: With control bit 4 set, the synchronization timer (0x14) rises by one on each clock. When control bit 5 is set, a high debug-halt input holds it.
- R6: Writing the control word with bit 31 adds the adjustment register (0x08) to the synchronization timer. Bit 30 subtracts it, bit 29 loads it, and bit 28 clears the timer. The command takes effect on the clock after the write and replaces that clock's increment. Arithmetic wraps modulo 2^32.
- R7: When several command bits are written together, clear wins over load, load wins over add, and add wins over subtract.
- R8: The control word reads back bits 0, 1, 2, 4 and 5 as written, and reads zero in every other bit, including the command bits.
- R9: On a clock where the trigger input is high and was low on the previous clock, the capture register (0x10) takes the synchronization timer value of that cycle. Otherwise the capture register holds.
- R10: The map is control 0x00, limit 0x04, adjustment 0x08, counter 0x0C, capture 0x10, timer 0x14, compares 0x20 to 0x2C. Writes to the read-only words have no effect, and the reserved words 0x18 and 0x1C read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 6 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| dbg_halt | input | 1 | Debug-halt request |
| trig_in | input | 1 | Capture trigger, rising-edge active |
| cmp_hit | output | 4 | Compare pulses, one bit per channel |

## Verification
A register write takes effect at the edge that samples it. Counter steps and compare pulses are visible right after the edge that computes them. A synchronization-timer command shows its result one edge after the write edge, and a capture shows after the edge on which the trigger rise is seen. The bench holds a behavioural model that it advances at each rising edge from the same inputs. About one nanosecond after every edge, before it drives anything new, it compares both the pulse vector and the read data of the currently addressed word. A few hand-computed values are also checked at the exact edge on which each command resolves.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int STM_DW = 32;
  localparam int STM_AW = 6;

  typedef logic [STM_DW-1:0] word_t;

  // word indices (byte address / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_LIM  = 1;
  localparam int IDX_ADJ  = 2;
  localparam int IDX_CNT  = 3;
  localparam int IDX_CAP  = 4;
  localparam int IDX_SYNC = 5;
  localparam int IDX_CMP0 = 8;

  // control word bit positions
  localparam int B_CNT_EN   = 0;
  localparam int B_CNT_CLR  = 1;
  localparam int B_CNT_HOLD = 2;
  localparam int B_SYN_EN   = 4;
  localparam int B_SYN_HOLD = 5;
  localparam int B_CMD_LO   = 28;

  // packed so that it lines up with control bits 31..28
  typedef struct packed {
    logic add;
    logic sub;
    logic load;
    logic zero;
  } cmd_t;

  function automatic word_t wrap_step(word_t cur, word_t lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction

  function automatic word_t sync_next(cmd_t c, word_t cur, word_t adj, logic run);
    if (c.zero)      return '0;
    else if (c.load) return adj;
    else if (c.add)  return cur + adj;
    else if (c.sub)  return cur - adj;
    else if (run)    return cur + 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/stm_regs.sv
module stm_regs
  import stm_pkg::*;
#(
  parameter int NCMP = 4,
  parameter int AW   = STM_AW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  word_t                  reg_wdata,
  output word_t                  reg_rdata,
  input  word_t                  cnt_val,
  input  word_t                  cap_val,
  input  word_t                  sync_val,
  output logic                   cnt_en,
  output logic                   cnt_clr,
  output logic                   cnt_hold,
  output logic                   syn_en,
  output logic                   syn_hold,
  output word_t                  lim_q,
  output word_t                  adj_q,
  output logic [NCMP-1:0][STM_DW-1:0] match_q,
  output cmd_t                   cmd_pend
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] IX_CTRL = IW'(IDX_CTRL);
  localparam logic [IW-1:0] IX_LIM  = IW'(IDX_LIM);
  localparam logic [IW-1:0] IX_ADJ  = IW'(IDX_ADJ);
  localparam logic [IW-1:0] IX_CNT  = IW'(IDX_CNT);
  localparam logic [IW-1:0] IX_CAP  = IW'(IDX_CAP);
  localparam logic [IW-1:0] IX_SYNC = IW'(IDX_SYNC);

  logic [IW-1:0] idx;
  logic          wr_ctrl;
  assign idx     = reg_addr[AW-1:2];
  assign wr_ctrl = reg_wr && (idx == IX_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en   <= 1'b0;
      cnt_clr  <= 1'b0;
      cnt_hold <= 1'b0;
      syn_en   <= 1'b0;
      syn_hold <= 1'b0;
      lim_q    <= '0;
      adj_q    <= '0;
      cmd_pend <= '0;
    end else begin
      cmd_pend <= wr_ctrl ? cmd_t'(reg_wdata[B_CMD_LO +: 4]) : '0;
      if (wr_ctrl) begin
        cnt_en   <= reg_wdata[B_CNT_EN];
        cnt_clr  <= reg_wdata[B_CNT_CLR];
        cnt_hold <= reg_wdata[B_CNT_HOLD];
        syn_en   <= reg_wdata[B_SYN_EN];
        syn_hold <= reg_wdata[B_SYN_HOLD];
      end
      if (reg_wr && idx == IX_LIM) lim_q <= reg_wdata;
      if (reg_wr && idx == IX_ADJ) adj_q <= reg_wdata;
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   match_q[k] <= '0;
      else if (reg_wr && idx == IW'(IDX_CMP0 + k))  match_q[k] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (idx)
      IX_CTRL: begin
        reg_rdata[B_CNT_EN]   = cnt_en;
        reg_rdata[B_CNT_CLR]  = cnt_clr;
        reg_rdata[B_CNT_HOLD] = cnt_hold;
        reg_rdata[B_SYN_EN]   = syn_en;
        reg_rdata[B_SYN_HOLD] = syn_hold;
      end
      IX_LIM:  reg_rdata = lim_q;
      IX_ADJ:  reg_rdata = adj_q;
      IX_CNT:  reg_rdata = cnt_val;
      IX_CAP:  reg_rdata = cap_val;
      IX_SYNC: reg_rdata = sync_val;
      default: begin
        for (int k = 0; k < NCMP; k++)
          if (idx == IW'(IDX_CMP0 + k)) reg_rdata = match_q[k];
      end
    endcase
  end
endmodule

// File: rtl/stm_period.sv
module stm_period
  import stm_pkg::*;
#(
  parameter int NCMP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic                   cnt_clr,
  input  logic                   cnt_hold,
  input  logic                   dbg_halt,
  input  word_t                  lim_q,
  input  logic [NCMP-1:0][STM_DW-1:0] match_q,
  output word_t                  cnt_q,
  output logic                   cnt_step,
  output logic [NCMP-1:0]        hit_q
);
  word_t cnt_nxt;

  assign cnt_step = cnt_en && !cnt_clr && !(cnt_hold && dbg_halt);

  always_comb begin
    if (cnt_clr)       cnt_nxt = '0;
    else if (cnt_step) cnt_nxt = wrap_step(cnt_q, lim_q);
    else               cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q[k] <= 1'b0;
      else        hit_q[k] <= cnt_step && (cnt_nxt != cnt_q) && (cnt_nxt == match_q[k]);
    end
  end
endmodule

// File: rtl/stm_sync.sv
module stm_sync
  import stm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  syn_en,
  input  logic  syn_hold,
  input  logic  dbg_halt,
  input  cmd_t  cmd_pend,
  input  word_t adj_q,
  input  logic  trig_in,
  output logic  trig_rise,
  output word_t sync_q,
  output word_t cap_q
);
  logic trig_d;
  logic run;

  assign run       = syn_en && !(syn_hold && dbg_halt);
  assign trig_rise = trig_in && !trig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_d <= 1'b0;
      sync_q <= '0;
      cap_q  <= '0;
    end else begin
      trig_d <= trig_in;
      sync_q <= sync_next(cmd_pend, sync_q, adj_q, run);
      if (trig_rise) cap_q <= sync_q;
    end
  end
endmodule

// File: rtl/sync_timer_unit.sv
module sync_timer_unit
  import stm_pkg::*;
#(
  parameter int NCMP = 4,
  parameter int AW   = STM_AW,
  parameter int DW   = STM_DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            dbg_halt,
  input  logic            trig_in,
  output logic [NCMP-1:0] cmp_hit
);
  logic  cnt_en, cnt_clr, cnt_hold, syn_en, syn_hold;
  logic  cnt_step, trig_rise;
  word_t lim_q, adj_q, cnt_q, sync_q, cap_q;
  logic [NCMP-1:0][STM_DW-1:0] match_q;
  cmd_t  cmd_pend;

  stm_regs #(.NCMP(NCMP), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_val(cnt_q), .cap_val(cap_q), .sync_val(sync_q),
    .cnt_en(cnt_en), .cnt_clr(cnt_clr), .cnt_hold(cnt_hold),
    .syn_en(syn_en), .syn_hold(syn_hold),
    .lim_q(lim_q), .adj_q(adj_q), .match_q(match_q), .cmd_pend(cmd_pend)
  );

  stm_period #(.NCMP(NCMP)) period_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
    .cnt_hold(cnt_hold), .dbg_halt(dbg_halt), .lim_q(lim_q),
    .match_q(match_q), .cnt_q(cnt_q), .cnt_step(cnt_step), .hit_q(cmp_hit)
  );

  stm_sync sync_i (
    .clk(clk), .rst_n(rst_n), .syn_en(syn_en), .syn_hold(syn_hold),
    .dbg_halt(dbg_halt), .cmd_pend(cmd_pend), .adj_q(adj_q),
    .trig_in(trig_in), .trig_rise(trig_rise), .sync_q(sync_q), .cap_q(cap_q)
  );
endmodule

// File: rtl/stm_chk.sv
module stm_chk #(
  parameter int NCMP = 4,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [AW-1:0]   reg_addr,
  input logic [31:0]     reg_rdata,
  input logic            dbg_halt,
  input logic            cnt_hold,
  input logic            cnt_clr,
  input logic [31:0]     cnt_q,
  input logic [3:0]      cmd_pend,
  input logic            trig_rise,
  input logic [31:0]     sync_q,
  input logic [31:0]     cap_q,
  input logic [NCMP-1:0] cmp_hit
);
  AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmp_hit) |=> ((cmp_hit & $past(cmp_hit)) == '0)); // R4

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pend != 4'd0) && !(reg_wr && reg_addr[AW-1:2] == '0)) |=> (cmd_pend == 4'd0)); // R6

  AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pend[0] |=> (sync_q == 32'd0)); // R7

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_hold && dbg_halt && !cnt_clr) |=> $stable(cnt_q)); // R3

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> (cap_q == $past(sync_q))); // R9

  AST_CMD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[AW-1:2] == '0) |-> (reg_rdata[31:28] == 4'd0)); // R8
endmodule

bind sync_timer_unit stm_chk #(.NCMP(NCMP), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .cnt_hold(cnt_hold),
  .cnt_clr(cnt_clr), .cnt_q(cnt_q), .cmd_pend(cmd_pend),
  .trig_rise(trig_rise), .sync_q(sync_q), .cap_q(cap_q), .cmp_hit(cmp_hit)
);

// File: tb/sync_timer_unit_tb_top.sv
`timescale 1ns/1ps
module sync_timer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_halt = 1'b0;
  logic        trig_in = 1'b0;
  logic [3:0]  cmp_hit;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";

  always #4 clk = ~clk;

  sync_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt),
    .trig_in(trig_in), .cmp_hit(cmp_hit)
  );

  // behavioural reference
  logic [31:0] m_ctrl, m_lim, m_adj, m_cnt, m_cap, m_sync;
  logic [31:0] m_cmp [4];
  logic [3:0]  m_pend, m_hit;
  logic        m_trigd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_lim = 0; m_adj = 0; m_cnt = 0; m_cap = 0; m_sync = 0;
      for (int i = 0; i < 4; i++) m_cmp[i] = 0;
      m_pend = 0; m_hit = 0; m_trigd = 0;
    end else begin
      logic [31:0] nc, ns;
      logic        going, sy_run;
      going = m_ctrl[0] && !m_ctrl[1] && !(m_ctrl[2] && dbg_halt);
      if (m_ctrl[1])  nc = 0;
      else if (going) nc = (m_cnt == m_lim) ? 32'd0 : m_cnt + 32'd1;
      else            nc = m_cnt;
      for (int i = 0; i < 4; i++) m_hit[i] = going && (nc != m_cnt) && (nc == m_cmp[i]);
      sy_run = m_ctrl[4] && !(m_ctrl[5] && dbg_halt);
      if (m_pend[0])      ns = 0;
      else if (m_pend[1]) ns = m_adj;
      else if (m_pend[3]) ns = m_sync + m_adj;
      else if (m_pend[2]) ns = m_sync - m_adj;
      else if (sy_run)    ns = m_sync + 32'd1;
      else                ns = m_sync;
      if (trig_in && !m_trigd) m_cap = m_sync;
      m_trigd = trig_in;
      m_cnt = nc;
      m_sync = ns;
      m_pend = 0;
      if (reg_wr) begin
        case (reg_addr)
          6'h00: begin m_ctrl = reg_wdata & 32'h37; m_pend = reg_wdata[31:28]; end
          6'h04: m_lim = reg_wdata;
          6'h08: m_adj = reg_wdata;
          6'h20, 6'h24, 6'h28, 6'h2C: m_cmp[(reg_addr - 6'h20) >> 2] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    case (a)
      6'h00: return m_ctrl;
      6'h04: return m_lim;
      6'h08: return m_adj;
      6'h0C: return m_cnt;
      6'h10: return m_cap;
      6'h14: return m_sync;
      6'h20, 6'h24, 6'h28, 6'h2C: return m_cmp[(a - 6'h20) >> 2];
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", req, reg_addr, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("R4", {28'd0, cmp_hit}, {28'd0, m_hit});
    chk(cur_req, reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [5:0] rd_a);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = rd_a;
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state on every word
    #3;
    for (int a = 0; a < 64; a += 4) begin
      reg_addr = 6'(a);
      #1;
      chk("R1", reg_rdata, 32'd0);
    end
    chk("R1", {28'd0, cmp_hit}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: map, read-only and reserved words
    cur_req = "R10";
    wr(6'h04, 32'd5, 6'h04);
    wr(6'h20, 32'd3, 6'h20);
    wr(6'h24, 32'd5, 6'h24);
    wr(6'h28, 32'd0, 6'h28);
    wr(6'h2C, 32'd9, 6'h2C);
    wr(6'h0C, 32'hDEAD_BEEF, 6'h0C);
    tick();
    chk("R10", reg_rdata, 32'd0);
    wr(6'h18, 32'h1234_5678, 6'h18);
    tick();
    wr(6'h14, 32'h0000_00FF, 6'h1C);
    tick();

    // R2: counting and wrap at limit
    cur_req = "R2";
    wr(6'h00, 32'h1, 6'h0C);
    ticks(16);

    // R3: debug freeze of the counter
    cur_req = "R3";
    wr(6'h00, 32'h5, 6'h0C);
    dbg_halt = 1'b1;
    ticks(6);
    dbg_halt = 1'b0;
    ticks(4);

    // R2: forced clear
    cur_req = "R2";
    wr(6'h00, 32'h3, 6'h0C);
    ticks(3);
    chk("R2", reg_rdata, 32'd0);
    wr(6'h00, 32'h1, 6'h0C);
    ticks(4);

    // R5: sync timer run and freeze
    cur_req = "R5";
    wr(6'h00, 32'h11, 6'h14);
    ticks(5);
    wr(6'h00, 32'h31, 6'h14);
    dbg_halt = 1'b1;
    ticks(4);
    dbg_halt = 1'b0;
    ticks(2);
    wr(6'h00, 32'h01, 6'h14);
    ticks(3);

    // R6: commands
    cur_req = "R6";
    wr(6'h08, 32'd100, 6'h14);
    wr(6'h00, 32'h2000_0011, 6'h14);
    tick();
    chk("R6", reg_rdata, 32'd100);
    wr(6'h00, 32'h8000_0011, 6'h14);
    ticks(2);
    wr(6'h00, 32'h4000_0011, 6'h14);
    wr(6'h00, 32'h8000_0011, 6'h14);
    ticks(2);
    wr(6'h00, 32'h1000_0001, 6'h14);
    wr(6'h08, 32'd1, 6'h14);
    wr(6'h00, 32'h4000_0001, 6'h14);
    tick();
    chk("R6", reg_rdata, 32'hFFFF_FFFF);
    ticks(2);

    // R7: priority among commands (timer stopped)
    cur_req = "R7";
    wr(6'h08, 32'd50, 6'h14);
    wr(6'h00, 32'hF000_0001, 6'h14);
    tick();
    chk("R7", reg_rdata, 32'd0);
    wr(6'h00, 32'hE000_0001, 6'h14);
    tick();
    chk("R7", reg_rdata, 32'd50);
    wr(6'h00, 32'hC000_0001, 6'h14);
    tick();
    chk("R7", reg_rdata, 32'd100);

    // R8: control readback
    cur_req = "R8";
    wr(6'h00, 32'hFFFF_FFFF, 6'h00);
    chk("R8", reg_rdata, 32'h37);
    ticks(2);
    wr(6'h00, 32'hF000_0033, 6'h00);
    chk("R8", reg_rdata, 32'h33);
    ticks(2);

    // R9: trigger capture
    cur_req = "R9";
    wr(6'h00, 32'h11, 6'h10);
    ticks(3);
    trig_in = 1'b1;
    ticks(3);
    trig_in = 1'b0;
    ticks(4);
    trig_in = 1'b1;
    tick();
    trig_in = 1'b0;
    ticks(3);
    reg_addr = 6'h14;
    ticks(2);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule